// File: doc/BRIEF.md
# SMBus Master Arbitration and Timing Supervisor

This block sits beside a byte-level SMBus master controller and gives it a programmable bit-timing tick and bus supervision. A 16-bit divider value sets the tick period in base-clock cycles, and the values 0 and 1 stop the tick entirely. The divider resets to one of two defaults chosen by a boot strap: 0x0139 for standard 100 kHz operation and 0x0053 for 400 kHz operation. With a 31.25 MHz base clock, one count equals 32 ns.

While a transaction is open, the supervisor compares the level the master is driving on SDA with the sampled bus. When the master has released SDA, SCL is high and SDA reads low, the master has lost arbitration. The supervisor then waits for the bus to go idle and tells the controller to try again. A run of 16 such losses with no win in between aborts the transaction and raises a sticky error flag. A bypass control makes the master carry on regardless, so no loss is ever counted. A second detector raises another sticky flag when a START or STOP condition shows up while the controller has not opened its condition window. Each flag is cleared by writing a 1 to its bit.

The control state machine has these states. ARB_IDLE means no transaction is open. ARB_ACTIVE is a transaction in progress. ARB_LOST is a one-cycle loss report. ARB_WAIT_IDLE waits for the bus to go quiet. ARB_RETRY is a one-cycle restart strobe. ARB_ABORT is a one-cycle abort strobe. Its transitions are:
- ARB_IDLE to ARB_ACTIVE on an accepted request.
- ARB_ACTIVE to ARB_IDLE on done, which counts as a win.
- ARB_ACTIVE to ARB_LOST on a loss below the limit.
- ARB_ACTIVE to ARB_ABORT on the loss that reaches the limit.
- ARB_LOST to ARB_WAIT_IDLE, unconditionally.
- ARB_WAIT_IDLE to ARB_RETRY once the bus has been idle long enough.
- ARB_RETRY to ARB_ACTIVE, unconditionally.
- ARB_ABORT to ARB_IDLE, unconditionally.

Top module: `smbus_arb_supervisor`

## Requirements
- R1: After reset `prescale_q` reads 0x0139 when `boot_fast` is 0 and 0x0053 when it is 1. At the same time `ignore_q`, both error flags, `txn_active` and `retry_count` read 0, and `drv_level` reads 1.
- R2: A control write takes the divider P from `ctrl_wdata[15:0]` and the bypass bit from `ctrl_wdata[16]`. With P of 2 or more, `tick` pulses for one cycle, and consecutive pulses are exactly P cycles apart.
- R3: With P equal to 0 or 1, `tick` never asserts.
- R4: In ARB_ACTIVE with the driven level released (`drv_level`=1), a cycle with `scl_in`=1 and `sda_in`=0 and the bypass off makes `arb_lost` pulse in the next cycle. In that cycle `retry_count` has grown by one.
- R5: After a loss, `retry_go` pulses only once `scl_in` and `sda_in` have both been high on P consecutive clock edges (one edge when P is below 2). The pulse appears in the cycle after the last of those edges. After it the transaction is active again with the driven level released.
- R6: The 16th consecutive loss pulses `txn_abort` instead of `retry_go`, sets `err_lost_arb` and returns to ARB_IDLE. In the abort cycle `retry_count` reads 16.
- R7: `retry_count` returns to 0 when `txn_done` closes an active transaction (a win) and when a new `txn_req` is accepted in ARB_IDLE.
- R8: With the bypass bit set, the loss pattern of R4 leaves `arb_lost` low and `retry_count` unchanged, and the transaction stays active.
- R9: In ARB_ACTIVE with `cond_ok` low, an SDA change while SCL is high on two consecutive edges sets `err_other`. A falling SDA is a START and a rising SDA is a STOP. The same conditions with `cond_ok` high leave it clear.
- R10: Error flags stay set until cleared. A cycle with `err_clr_we` high clears `err_lost_arb` where `err_clr_data[0]` is 1 and `err_other` where `err_clr_data[1]` is 1, leaving the other flag untouched.
- R11: While the driven level is 0 (set by `bit_drive` with `bit_val`=0), a low SDA with SCL high is never a loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_fast | input | 1 | Strap: 1 selects the 400 kHz divider default |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_wdata | input | 17 | [15:0] divider, [16] ignore arbitration |
| err_clr_we | input | 1 | Error clear strobe |
| err_clr_data | input | 2 | Write-1-to-clear mask: [0] lost-arb, [1] other |
| txn_req | input | 1 | Controller start strobe |
| bit_drive | input | 1 | Controller strobe: new SDA level to drive |
| bit_val | input | 1 | SDA level driven (1 = released) |
| cond_ok | input | 1 | Controller is generating a START/STOP now |
| txn_done | input | 1 | Controller done strobe (transaction won) |
| scl_in | input | 1 | Synchronised SCL level |
| sda_in | input | 1 | Synchronised SDA level |
| prescale_q | output | 16 | Current divider value |
| ignore_q | output | 1 | Current bypass bit |
| err_lost_arb | output | 1 | Sticky abort-after-losses flag |
| err_other | output | 1 | Sticky misplaced START/STOP flag |
| tick | output | 1 | Bit-timing tick |
| txn_active | output | 1 | A transaction is open |
| drv_level | output | 1 | SDA level the master drives |
| arb_lost | output | 1 | One-cycle loss report |
| retry_go | output | 1 | One-cycle restart strobe |
| txn_abort | output | 1 | One-cycle abort strobe |
| retry_count | output | 5 | Consecutive losses in this transaction |

## Verification
The properties assume that `scl_in` and `sda_in` are already synchronised to `clk`. They also assume the controller raises `txn_req` only while `txn_active` is low and `txn_done` only while a transaction is open. The stimulus changes the bus lines one at a time, so only the intended condition occurs. It lowers SCL before moving SDA so that loss patterns produce no accidental START or STOP. It applies deliberate START/STOP edges only with the bypass bit set, so that a low SDA under high SCL cannot also count as a loss.

// File: rtl/smbsup_pkg.sv
package smbsup_pkg;

    typedef enum logic [2:0] {
        ARB_IDLE,
        ARB_ACTIVE,
        ARB_LOST,
        ARB_WAIT_IDLE,
        ARB_RETRY,
        ARB_ABORT
    } arb_state_t;

    localparam int ERR_LOST_BIT  = 0;
    localparam int ERR_OTHER_BIT = 1;
    localparam int ERR_W         = 2;

endpackage

// File: rtl/smbsup_prescaler.sv
module smbsup_prescaler #(
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [PRE_W-1:0] divider,
    output logic             tick
);
    logic [PRE_W-1:0] cnt_q;
    logic             running;
    logic             at_end;

    assign running = (divider > PRE_W'(1));
    assign at_end  = (cnt_q == divider - PRE_W'(1));
    assign tick    = running && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || !running || at_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PRE_W'(1);
        end
    end
endmodule

// File: rtl/smbsup_ctrl_regs.sv
module smbsup_ctrl_regs
    import smbsup_pkg::*;
#(
    parameter int          PRE_W     = 16,
    parameter logic [15:0] SLOW_INIT = 16'h0139,
    parameter logic [15:0] FAST_INIT = 16'h0053
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boot_fast,
    input  logic             ctrl_we,
    input  logic [PRE_W:0]   ctrl_wdata,
    input  logic             err_clr_we,
    input  logic [ERR_W-1:0] err_clr_data,
    input  logic             set_lost,
    input  logic             set_other,
    output logic [PRE_W-1:0] prescale_q,
    output logic             ignore_q,
    output logic [ERR_W-1:0] err_q
);
    logic [ERR_W-1:0] clr_mask;
    logic [ERR_W-1:0] set_mask;

    always_comb begin
        clr_mask                = err_clr_we ? err_clr_data : '0;
        set_mask                = '0;
        set_mask[ERR_LOST_BIT]  = set_lost;
        set_mask[ERR_OTHER_BIT] = set_other;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prescale_q <= boot_fast ? PRE_W'(FAST_INIT) : PRE_W'(SLOW_INIT);
            ignore_q   <= 1'b0;
        end else if (ctrl_we) begin
            prescale_q <= ctrl_wdata[PRE_W-1:0];
            ignore_q   <= ctrl_wdata[PRE_W];
        end
    end

    // Setting wins over a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= '0;
        end else begin
            err_q <= (err_q & ~clr_mask) | set_mask;
        end
    end
endmodule

// File: rtl/smbsup_cond_det.sv
module smbsup_cond_det (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic window,
    input  logic cond_ok,
    output logic misplaced
);
    logic scl_q;
    logic sda_q;
    logic start_seen;
    logic stop_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
        end
    end

    assign start_seen = scl_q && scl_in && sda_q && !sda_in;
    assign stop_seen  = scl_q && scl_in && !sda_q && sda_in;
    assign misplaced  = window && !cond_ok && (start_seen || stop_seen);
endmodule

// File: rtl/smbsup_arb_fsm.sv
module smbsup_arb_fsm
    import smbsup_pkg::*;
#(
    parameter int  PRE_W      = 16,
    parameter int  LOSS_LIMIT = 16,
    localparam int CNT_W      = $clog2(LOSS_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] prescale,
    input  logic             ignore,
    input  logic             txn_req,
    input  logic             bit_drive,
    input  logic             bit_val,
    input  logic             txn_done,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             in_active,
    output logic             txn_active,
    output logic             drv_level,
    output logic             arb_lost,
    output logic             retry_go,
    output logic             txn_abort,
    output logic             abort_now,
    output logic [CNT_W-1:0] loss_count
);
    arb_state_t       st_q;
    arb_state_t       st_d;
    logic             drv_q;
    logic [CNT_W-1:0] loss_q;
    logic [PRE_W-1:0] idle_q;
    logic             bus_idle;
    logic             lost_now;
    logic             at_limit;
    logic             idle_met;
    logic [PRE_W:0]   idle_thr;
    logic [PRE_W:0]   idle_next;

    assign bus_idle  = scl_in && sda_in;
    assign lost_now  = (st_q == ARB_ACTIVE) && drv_q && scl_in && !sda_in
                       && !ignore && !txn_done;
    assign at_limit  = (loss_q == CNT_W'(LOSS_LIMIT - 1));
    assign idle_thr  = (prescale < PRE_W'(2)) ? (PRE_W+1)'(1) : {1'b0, prescale};
    assign idle_next = {1'b0, idle_q} + (PRE_W+1)'(1);
    assign idle_met  = bus_idle && (idle_next >= idle_thr);

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ARB_IDLE:      if (txn_req) st_d = ARB_ACTIVE;
            ARB_ACTIVE: begin
                if (txn_done)      st_d = ARB_IDLE;
                else if (lost_now) st_d = at_limit ? ARB_ABORT : ARB_LOST;
            end
            ARB_LOST:      st_d = ARB_WAIT_IDLE;
            ARB_WAIT_IDLE: if (idle_met) st_d = ARB_RETRY;
            ARB_RETRY:     st_d = ARB_ACTIVE;
            ARB_ABORT:     st_d = ARB_IDLE;
            default:       st_d = ARB_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ARB_IDLE;
        else        st_q <= st_d;
    end

    // Datapath registers owned by the state machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q  <= 1'b1;
            loss_q <= '0;
            idle_q <= '0;
        end else begin
            unique case (st_q)
                ARB_IDLE: begin
                    if (txn_req) begin
                        loss_q <= '0;
                        drv_q  <= 1'b1;
                    end
                end
                ARB_ACTIVE: begin
                    if (txn_done) begin
                        loss_q <= '0;
                        drv_q  <= 1'b1;
                    end else if (lost_now) begin
                        loss_q <= loss_q + CNT_W'(1);
                    end else if (bit_drive) begin
                        drv_q <= bit_val;
                    end
                end
                ARB_LOST:      idle_q <= '0;
                ARB_WAIT_IDLE: idle_q <= bus_idle ? idle_next[PRE_W-1:0] : '0;
                ARB_RETRY:     drv_q  <= 1'b1;
                ARB_ABORT:     drv_q  <= 1'b1;
                default:       drv_q  <= 1'b1;
            endcase
        end
    end

    // Outputs
    always_comb begin
        in_active  = (st_q == ARB_ACTIVE);
        txn_active = (st_q != ARB_IDLE);
        arb_lost   = (st_q == ARB_LOST);
        retry_go   = (st_q == ARB_RETRY);
        txn_abort  = (st_q == ARB_ABORT);
        abort_now  = lost_now && at_limit;
        drv_level  = drv_q;
        loss_count = loss_q;
    end
endmodule

// File: rtl/smbus_arb_supervisor.sv
module smbus_arb_supervisor
    import smbsup_pkg::*;
#(
    parameter int          PRE_W      = 16,
    parameter int          LOSS_LIMIT = 16,
    parameter logic [15:0] SLOW_INIT  = 16'h0139,
    parameter logic [15:0] FAST_INIT  = 16'h0053,
    localparam int         CNT_W      = $clog2(LOSS_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boot_fast,
    input  logic             ctrl_we,
    input  logic [PRE_W:0]   ctrl_wdata,
    input  logic             err_clr_we,
    input  logic [1:0]       err_clr_data,
    input  logic             txn_req,
    input  logic             bit_drive,
    input  logic             bit_val,
    input  logic             cond_ok,
    input  logic             txn_done,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic [PRE_W-1:0] prescale_q,
    output logic             ignore_q,
    output logic             err_lost_arb,
    output logic             err_other,
    output logic             tick,
    output logic             txn_active,
    output logic             drv_level,
    output logic             arb_lost,
    output logic             retry_go,
    output logic             txn_abort,
    output logic [CNT_W-1:0] retry_count
);
    logic             in_active;
    logic             abort_now;
    logic             misplaced;
    logic [ERR_W-1:0] err_q;

    smbsup_ctrl_regs #(
        .PRE_W(PRE_W), .SLOW_INIT(SLOW_INIT), .FAST_INIT(FAST_INIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .boot_fast(boot_fast),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .err_clr_we(err_clr_we), .err_clr_data(err_clr_data),
        .set_lost(abort_now), .set_other(misplaced),
        .prescale_q(prescale_q), .ignore_q(ignore_q), .err_q(err_q)
    );

    smbsup_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(ctrl_we),
        .divider(prescale_q), .tick(tick)
    );

    smbsup_arb_fsm #(.PRE_W(PRE_W), .LOSS_LIMIT(LOSS_LIMIT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .prescale(prescale_q), .ignore(ignore_q),
        .txn_req(txn_req), .bit_drive(bit_drive), .bit_val(bit_val),
        .txn_done(txn_done), .scl_in(scl_in), .sda_in(sda_in),
        .in_active(in_active), .txn_active(txn_active), .drv_level(drv_level),
        .arb_lost(arb_lost), .retry_go(retry_go), .txn_abort(txn_abort),
        .abort_now(abort_now), .loss_count(retry_count)
    );

    smbsup_cond_det u_cond (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .window(in_active), .cond_ok(cond_ok), .misplaced(misplaced)
    );

    assign err_lost_arb = err_q[ERR_LOST_BIT];
    assign err_other    = err_q[ERR_OTHER_BIT];
endmodule

// File: rtl/smbsup_checker.sv
module smbsup_checker #(
    parameter int PRE_W = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             err_clr_we,
    input logic [1:0]       err_clr_data,
    input logic             scl_in,
    input logic             sda_in,
    input logic [PRE_W-1:0] prescale_q,
    input logic             ignore_q,
    input logic             err_lost_arb,
    input logic             err_other,
    input logic             tick,
    input logic             arb_lost,
    input logic             retry_go,
    input logic             txn_abort,
    input logic [CNT_W-1:0] retry_count
);
    p_tick_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (prescale_q < PRE_W'(2)) |-> !tick);

    p_loss_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> (retry_count == $past(retry_count) + CNT_W'(1)));

    p_retry_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        retry_go |-> $past(scl_in && sda_in));

    p_abort_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        txn_abort |-> err_lost_arb);

    p_single_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arb_lost, retry_go, txn_abort}));

    p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> !$past(ignore_q));

    p_sticky_lost_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_lost_arb && !(err_clr_we && err_clr_data[0])) |=> err_lost_arb);

    p_sticky_other_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_other && !(err_clr_we && err_clr_data[1])) |=> err_other);
endmodule

bind smbus_arb_supervisor smbsup_checker #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .err_clr_we(err_clr_we), .err_clr_data(err_clr_data),
    .scl_in(scl_in), .sda_in(sda_in), .prescale_q(prescale_q), .ignore_q(ignore_q),
    .err_lost_arb(err_lost_arb), .err_other(err_other), .tick(tick),
    .arb_lost(arb_lost), .retry_go(retry_go), .txn_abort(txn_abort),
    .retry_count(retry_count)
);

// File: tb/smbus_arb_supervisor_bench.sv
module smbus_arb_supervisor_bench;
    localparam int P = 4;

    logic        clk = 1'b0;
    logic        rst_n, boot_fast, ctrl_we, err_clr_we;
    logic [16:0] ctrl_wdata;
    logic [1:0]  err_clr_data;
    logic        txn_req, bit_drive, bit_val, cond_ok, txn_done, scl_in, sda_in;
    logic [15:0] prescale_q;
    logic        ignore_q, err_lost_arb, err_other, tick, txn_active, drv_level;
    logic        arb_lost, retry_go, txn_abort;
    logic [4:0]  retry_count;

    always #5 clk = ~clk;

    smbus_arb_supervisor u_smbus_arb_supervisor (.*);

    typedef enum int {EV_LOST, EV_RETRY, EV_ABORT} ev_kind_t;
    typedef struct { ev_kind_t kind; int cnt; } ev_t;
    ev_t exp_q[$];

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input ev_kind_t k, input int c);
        ev_t e;
        e.kind = k;
        e.cnt  = c;
        exp_q.push_back(e);
    endtask

    task automatic do_reset(input logic fast);
        rst_n = 1'b0; boot_fast = fast; ctrl_we = 0; ctrl_wdata = '0;
        err_clr_we = 0; err_clr_data = '0; txn_req = 0; bit_drive = 0;
        bit_val = 1; cond_ok = 0; txn_done = 0; scl_in = 1; sda_in = 1;
        repeat (3) step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic write_ctrl(input logic ign, input logic [15:0] div);
        ctrl_we = 1; ctrl_wdata = {ign, div}; step(); ctrl_we = 0;
    endtask

    task automatic pulse_req();  txn_req = 1;  step(); txn_req = 0;  endtask
    task automatic pulse_done(); txn_done = 1; step(); txn_done = 0; endtask

    // Loss pattern without accidental START/STOP, then bus back to idle
    task automatic loss_pattern();
        scl_in = 0; step(); sda_in = 0; step(); scl_in = 1; step();
        scl_in = 0; step(); sda_in = 1; step(); scl_in = 1;
    endtask

    task automatic lose(input bit last);
        int n;
        loss_pattern();
        if (!last) begin
            n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (!retry_go && n < 40);
            chk("R5 idle wait before retry", n, P + 1);
            step();
        end else begin
            repeat (3) step();
        end
    endtask

    // Monitor / scoreboard for the strobes
    initial forever begin
        @(negedge clk);
        if (rst_n === 1'b1 && (arb_lost || retry_go || txn_abort)) begin
            ev_t      e;
            ev_kind_t got;
            got = arb_lost ? EV_LOST : (retry_go ? EV_RETRY : EV_ABORT);
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R4/R5/R6/R8 unexpected strobe actual=%0d expected=none", got);
            end else begin
                e = exp_q.pop_front();
                chk("R4/R5/R6 strobe kind", int'(got), int'(e.kind));
                chk("R4/R6 retry_count at strobe", int'(retry_count), e.cnt);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int gap;
        int seen;

        // R1 reset values, slow strap
        do_reset(1'b0);
        chk("R1 divider slow default", prescale_q, 16'h0139);
        chk("R1 ignore reset", ignore_q, 0);
        chk("R1 flags reset", {err_other, err_lost_arb}, 0);
        chk("R1 idle after reset", txn_active, 0);
        chk("R1 count reset", retry_count, 0);
        chk("R1 driven level released", drv_level, 1);

        // R2 tick period
        write_ctrl(1'b0, 16'd5);
        seen = 0;
        while (!seen) begin @(negedge clk); seen = tick; end
        gap = 0;
        do begin @(negedge clk); gap++; end while (!tick && gap < 40);
        chk("R2 tick spacing P=5", gap, 5);
        step();

        // R3 stalled divider values
        write_ctrl(1'b0, 16'd1);
        seen = 0;
        repeat (20) begin @(negedge clk); seen = seen | tick; end
        chk("R3 no tick with P=1", seen, 0);
        step();
        write_ctrl(1'b0, 16'd0);
        seen = 0;
        repeat (20) begin @(negedge clk); seen = seen | tick; end
        chk("R3 no tick with P=0", seen, 0);
        step();

        write_ctrl(1'b0, 16'(P));
        pulse_req();
        chk("R7 active after request", txn_active, 1);

        // R11 driving low never loses
        bit_drive = 1; bit_val = 0; step(); bit_drive = 0; bit_val = 1;
        chk("R11 driven level low", drv_level, 0);
        scl_in = 0; step(); sda_in = 0; step(); scl_in = 1; step(); step();
        chk("R11 no loss while driving 0", retry_count, 0);
        scl_in = 0; step(); sda_in = 1; step(); scl_in = 1; step();
        bit_drive = 1; bit_val = 1; step(); bit_drive = 0;
        chk("R11 driven level released again", drv_level, 1);

        // R4/R5: fifteen losses, each retried
        for (int k = 1; k <= 15; k++) begin
            push(EV_LOST, k);
            push(EV_RETRY, k);
            lose(1'b0);
        end
        chk("R4 count after 15 losses", retry_count, 15);
        chk("R5 active after retry", txn_active, 1);
        chk("R5 released after retry", drv_level, 1);

        // R7 win clears the count
        pulse_done();
        chk("R7 count cleared on win", retry_count, 0);
        chk("R7 idle after done", txn_active, 0);

        // R6: sixteen consecutive losses abort
        pulse_req();
        for (int k = 1; k <= 15; k++) begin
            push(EV_LOST, k);
            push(EV_RETRY, k);
            lose(1'b0);
        end
        push(EV_ABORT, 16);
        lose(1'b1);
        chk("R6 lost-arb flag set", err_lost_arb, 1);
        chk("R6 idle after abort", txn_active, 0);
        chk("R6 count holds 16", retry_count, 16);
        chk("R6 all strobes consumed", exp_q.size(), 0);

        // R7 new request clears the count
        pulse_req();
        chk("R7 count cleared on request", retry_count, 0);

        // R8 bypass: no loss counted
        write_ctrl(1'b1, 16'(P));
        loss_pattern();
        step(); step();
        chk("R8 no count with bypass", retry_count, 0);
        chk("R8 still active with bypass", txn_active, 1);

        // R9 conditions inside and outside the window
        cond_ok = 1; step();
        sda_in = 0; step(); sda_in = 1; step();
        cond_ok = 0; step(); step();
        chk("R9 allowed START/STOP ignored", err_other, 0);
        sda_in = 0; step(); step();
        chk("R9 misplaced START flagged", err_other, 1);
        sda_in = 1; step();
        pulse_done();

        // R10 per-bit write-1-to-clear
        err_clr_we = 1; err_clr_data = 2'b10; step(); err_clr_we = 0; err_clr_data = 0;
        step();
        chk("R10 other cleared", err_other, 0);
        chk("R10 lost-arb kept", err_lost_arb, 1);
        err_clr_we = 1; err_clr_data = 2'b01; step(); err_clr_we = 0; err_clr_data = 0;
        step();
        chk("R10 lost-arb cleared", err_lost_arb, 0);

        // R1 fast strap default
        do_reset(1'b1);
        chk("R1 divider fast default", prescale_q, 16'h0053);
        chk("R1 flags clear after reset", {err_other, err_lost_arb}, 0);

        finish_run();
    end
endmodule